// File: doc/BRIEF.md
# Double-Buffered Scan Serializer with Gated Test Clock

This block sits between a host register port and a serial test bus. The host writes bytes into three outgoing serial channels: the data line and two mode-select lines. It reads bytes back from one incoming serial channel. Every channel has two 8-bit stages. The host fills or drains one stage while the other stage shifts. The result is a continuous bit stream as long as the host keeps ahead of the bus.

The test clock is derived from the system clock. It runs at half the system rate: one system cycle high, then one cycle low. It is held low whenever an enabled outgoing channel has no bit to present, or the enabled incoming channel has no room for another bit. So the stream can neither underflow nor overflow. Bits leave least-significant first. Outgoing lines change on the falling test-clock edge, or while the clock is held low. The incoming line is sampled on the rising edge.

The incoming channel can take its bit from one of four sources, chosen by a 2-bit selector. A separate loop-around switch passes the external input pin straight to the outgoing data pin.

Top module: `scan_serializer`

## Requirements
- R1: While `rst_n` is low and one cycle after it, `tck` is 0, `out_ready` is 3'b111, `in_avail` is 0, and `tdo`, `tms0` and `tms1` are 0 (with `loop_around` low).
- R2: Each outgoing byte appears on its pin least-significant bit first, one bit per test-clock period. A pin never changes during a cycle in which `tck` is high.
- R3: `out_ready[i]` is high when the holding stage of channel i is free. A write with `out_ready[i]` low is discarded. A second byte can be written while the first one shifts.
- R4: When an enabled outgoing channel (`out_en` bit 0 = data, bit 1 = mode-select 0, bit 2 = mode-select 1) has no bit to present, `tck` stays low.
- R5: The incoming channel shifts its selected source bit in at each `tck` rise and assembles bytes least-significant bit first. `in_avail` is high while a byte waits on `in_rdata`. An `in_rd` pulse removes that byte.
- R6: When `in_en` is high and both incoming stages are full, `tck` stays low until the host reads.
- R7: When every enabled participant is ready, `tck` alternates: one system cycle high, one system cycle low.
- R8: `lpbk_sel` chooses the incoming source: 2'b00 external `tdi_pin`, 2'b01 the data channel, 2'b10 mode-select 0, 2'b11 mode-select 1.
- R9: While `loop_around` is high, `tdo` equals `tdi_pin`.
- R10: A disabled outgoing channel neither stalls `tck` nor consumes its stored byte. Its pin keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_en | input | 3 | Enables for the outgoing channels (0 data, 1 mode-select 0, 2 mode-select 1) |
| out_wr | input | 3 | Per-channel byte write strobes |
| out_wdata | input | 8 | Byte written by the active strobe |
| out_ready | output | 3 | Holding stage of each channel can take a byte |
| in_en | input | 1 | Enable for the incoming channel |
| in_rd | input | 1 | Pops the waiting incoming byte |
| in_rdata | output | 8 | Waiting incoming byte |
| in_avail | output | 1 | An incoming byte is waiting |
| lpbk_sel | input | 2 | Incoming source select |
| loop_around | input | 1 | Passes `tdi_pin` to `tdo` |
| tdi_pin | input | 1 | External serial input |
| tck | output | 1 | Gated test clock |
| tdo | output | 1 | Serial data output |
| tms0 | output | 1 | Mode-select output 0 |
| tms1 | output | 1 | Mode-select output 1 |

## Verification
The assertions assume that `out_en` and `in_en` change only while no enabled outgoing channel holds a partly shifted byte. They also assume that at most one `out_wr` bit is high in a cycle. The stimulus keeps to this by changing enables only right after a reset or on an idle bus, and by driving one write strobe per cycle. Write and read strobes are only raised half a cycle after the clock edge, so each one is seen by exactly one edge.

// File: rtl/scan_ser_pkg.sv
// Shared constants and types for the scan serializer.
package scan_ser_pkg;
    localparam int DATA_W  = 8;
    localparam int OUT_CH  = 3;
    localparam int CH_DATA = 0;
    localparam int CH_MS0  = 1;
    localparam int CH_MS1  = 2;

    typedef enum logic [1:0] {
        SRC_PIN  = 2'b00,
        SRC_DATA = 2'b01,
        SRC_MS0  = 2'b10,
        SRC_MS1  = 2'b11
    } in_src_e;
endpackage

// File: rtl/scan_tck_gate.sv
// Test clock generator: a register that is high for one system cycle and
// low for at least one. It rises only when the run condition holds.
// Assumes run is a function of registered channel state only.
module scan_tck_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);
    logic tck_q;

    // Toggle phase: a high phase always ends; a low phase ends only on run.
    always_ff @(posedge clk) begin
        if (!rst_n)     tck_q <= 1'b0;
        else if (tck_q) tck_q <= 1'b0;
        else if (run)   tck_q <= 1'b1;
    end

    assign tck  = tck_q;
    assign rise = !tck_q && run;
    assign fall = tck_q;
endmodule

// File: rtl/scan_out_chan.sv
// One outgoing channel. A holding stage takes host bytes. A shift stage
// presents bits LSB first and advances on each falling test-clock edge.
// When the shift stage is empty, the pin shows the last bit sent.
// Assumes en only changes while the shift stage is idle.
module scan_out_chan #(
    parameter int DW = scan_ser_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tck_hi,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          valid,
    output logic          pin
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic [DW-1:0] sreg, hold_q;
    logic [CW-1:0] cnt;
    logic          svalid, hfull, last_q;

    // Shift stage: consume on fall, refill from the holding stage while low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            cnt    <= '0;
            svalid <= 1'b0;
            last_q <= 1'b0;
        end else if (en && tck_hi && svalid) begin
            last_q <= sreg[0];
            if (cnt == LAST_BIT) begin
                cnt    <= '0;
                svalid <= hfull;
                if (hfull) sreg <= hold_q;
            end else begin
                cnt  <= cnt + 1'b1;
                sreg <= sreg >> 1;
            end
        end else if (en && !tck_hi && !svalid && hfull) begin
            sreg   <= hold_q;
            svalid <= 1'b1;
            cnt    <= '0;
        end
    end

    logic take_hold;
    assign take_hold = en && hfull &&
                       ((tck_hi && svalid && cnt == LAST_BIT) ||
                        (!tck_hi && !svalid));

    // Holding stage: accept a host byte only when free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            hfull  <= 1'b0;
        end else if (wr && !hfull) begin
            hold_q <= wdata;
            hfull  <= 1'b1;
        end else if (take_hold) begin
            hfull  <= 1'b0;
        end
    end

    assign ready = !hfull;
    assign valid = svalid;
    assign pin   = svalid ? sreg[0] : last_q;

    // R2
    pin_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck_hi |-> $stable(pin));
    // R3
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hfull) |=> $stable(hold_q));
endmodule

// File: rtl/scan_in_chan.sv
// Incoming channel. Bits enter the MSB end of a shift stage on each rising
// test-clock edge, so the first bit lands in bit 0. A complete byte moves
// to the holding stage for the host. If that stage is occupied, the shift
// stage stays full.
// Assumes rise is only asserted when full is low.
module scan_in_chan #(
    parameter int DW = scan_ser_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rise,
    input  logic          sdi,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          avail,
    output logic          full
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic [DW-1:0] sreg, hold_q, sh_next;
    logic [CW-1:0] cnt;
    logic          sfull, hfull, take, done, move;

    assign sh_next = {sdi, sreg[DW-1:1]};
    assign take    = en && rise;
    assign done    = take && (cnt == LAST_BIT);
    assign move    = (done || sfull) && !hfull;

    // Shift stage: collect bits and mark full when held back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            cnt   <= '0;
            sfull <= 1'b0;
        end else begin
            if (take) begin
                sreg <= sh_next;
                cnt  <= done ? '0 : cnt + 1'b1;
            end
            if (move)      sfull <= 1'b0;
            else if (done) sfull <= 1'b1;
        end
    end

    // Holding stage: filled by a finished byte, emptied by a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            hfull  <= 1'b0;
        end else if (move) begin
            hold_q <= done ? sh_next : sreg;
            hfull  <= 1'b1;
        end else if (rd && hfull) begin
            hfull  <= 1'b0;
        end
    end

    assign rdata = hold_q;
    assign avail = hfull;
    assign full  = sfull;

    // R5
    hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hfull && !rd) |=> (hfull && $stable(hold_q)));
endmodule

// File: rtl/scan_serializer.sv
// Top: three outgoing channels, one incoming channel, source selection and
// the test clock gate. The clock runs only when every enabled channel
// can move one bit.
// Assumes one-hot or zero out_wr per cycle.
module scan_serializer
    import scan_ser_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OUT_CH-1:0] out_en,
    input  logic [OUT_CH-1:0] out_wr,
    input  logic [DW-1:0]     out_wdata,
    output logic [OUT_CH-1:0] out_ready,
    input  logic              in_en,
    input  logic              in_rd,
    output logic [DW-1:0]     in_rdata,
    output logic              in_avail,
    input  logic [1:0]        lpbk_sel,
    input  logic              loop_around,
    input  logic              tdi_pin,
    output logic              tck,
    output logic              tdo,
    output logic              tms0,
    output logic              tms1
);
    logic [OUT_CH-1:0] out_valid, chan_pin;
    logic              in_full, run, rise, fall, sdi;

    // Run only when no enabled participant would starve or overflow.
    assign run = (&(~out_en | out_valid)) && !(in_en && in_full);

    scan_tck_gate u_gate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tck  (tck),
        .rise (rise),
        .fall (fall)
    );

    for (genvar i = 0; i < OUT_CH; i++) begin : g_out
        scan_out_chan #(.DW(DW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (out_en[i]),
            .tck_hi(fall),
            .wr    (out_wr[i]),
            .wdata (out_wdata),
            .ready (out_ready[i]),
            .valid (out_valid[i]),
            .pin   (chan_pin[i])
        );
    end

    // Pick the incoming bit source.
    always_comb begin
        unique case (in_src_e'(lpbk_sel))
            SRC_PIN:  sdi = tdi_pin;
            SRC_DATA: sdi = chan_pin[CH_DATA];
            SRC_MS0:  sdi = chan_pin[CH_MS0];
            SRC_MS1:  sdi = chan_pin[CH_MS1];
            default:  sdi = tdi_pin;
        endcase
    end

    scan_in_chan #(.DW(DW)) u_in (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_en),
        .rise (rise),
        .sdi  (sdi),
        .rd   (in_rd),
        .rdata(in_rdata),
        .avail(in_avail),
        .full (in_full)
    );

    assign tdo  = loop_around ? tdi_pin : chan_pin[CH_DATA];
    assign tms0 = chan_pin[CH_MS0];
    assign tms1 = chan_pin[CH_MS1];

    // R4
    out_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && |(out_en & ~out_valid)) |=> !tck);
    // R6
    in_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && in_en && in_full) |=> !tck);
    // R7
    tck_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && &(~out_en | out_valid) && !(in_en && in_full)) |=> tck);
endmodule

// File: tb/scan_serializer_tb.sv
// Bench: a behavioural model built from byte queues predicts every output
// and is compared at each falling system-clock edge.
module scan_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] out_en = '0, out_wr = '0, out_ready;
    logic [7:0] out_wdata = '0, in_rdata;
    logic       in_en = 1'b0, in_rd = 1'b0, in_avail;
    logic [1:0] lpbk_sel = 2'b00;
    logic       loop_around = 1'b0, tdi_pin, tck, tdo, tms0, tms1;
    logic [15:0] lfsr = 16'hACE1;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    scan_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .out_wr(out_wr),
        .out_wdata(out_wdata), .out_ready(out_ready), .in_en(in_en),
        .in_rd(in_rd), .in_rdata(in_rdata), .in_avail(in_avail),
        .lpbk_sel(lpbk_sel), .loop_around(loop_around), .tdi_pin(tdi_pin),
        .tck(tck), .tdo(tdo), .tms0(tms0), .tms1(tms1)
    );

    assign tdi_pin = lfsr[0];
    always @(negedge clk) lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] oq [3][$];
    bit         opres [3];
    int         opos  [3];
    bit         olast [3];
    bit         tck_m;
    logic [7:0] ibyte, ihold;
    int         icnt;
    bit         isfull, ihf;

    function automatic bit m_pin(input int i);
        return opres[i] ? oq[i][0][opos[i]] : olast[i];
    endfunction

    function automatic bit m_hold_full(input int i);
        return (oq[i].size() - int'(opres[i])) >= 1;
    endfunction

    always @(posedge clk) begin
        bit run, rise, fall, s, ihf0, done;
        cyc++;
        cmp_on = 1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                oq[i].delete(); opres[i] = 0; opos[i] = 0; olast[i] = 0;
            end
            tck_m = 0; ibyte = 0; ihold = 0; icnt = 0; isfull = 0; ihf = 0;
        end else begin
            run = 1;
            for (int i = 0; i < 3; i++) if (out_en[i] && !opres[i]) run = 0;
            if (in_en && isfull) run = 0;
            fall = tck_m;
            rise = !tck_m && run;
            case (lpbk_sel)
                2'b00: s = tdi_pin;
                2'b01: s = m_pin(0);
                2'b10: s = m_pin(1);
                default: s = m_pin(2);
            endcase
            for (int i = 0; i < 3; i++) begin
                bit hf;
                hf = m_hold_full(i);
                if (out_en[i]) begin
                    if (fall && opres[i]) begin
                        olast[i] = oq[i][0][opos[i]];
                        opos[i]++;
                        if (opos[i] == 8) begin
                            void'(oq[i].pop_front());
                            opos[i] = 0;
                            opres[i] = hf;
                        end
                    end else if (!fall && !opres[i] && hf) begin
                        opres[i] = 1;
                    end
                end
                if (out_wr[i] && !hf) oq[i].push_back(out_wdata);
            end
            ihf0 = ihf;
            done = 0;
            if (in_rd && ihf0) ihf = 0;
            if (in_en && rise) begin
                ibyte = {s, ibyte[7:1]};
                icnt++;
                if (icnt == 8) begin icnt = 0; isfull = 1; done = 1; end
            end
            if (isfull && !ihf0) begin ihold = ibyte; ihf = 1; isfull = 0; end
            if (fall) tck_m = 0; else if (rise) tck_m = 1;
        end
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Continuous compare against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(tck == tck_m, "R7 tck", tck, tck_m);
            check(tdo == (loop_around ? tdi_pin : m_pin(0)), "R2 tdo", tdo,
                  loop_around ? tdi_pin : m_pin(0));
            check(tms0 == m_pin(1), "R2 tms0", tms0, m_pin(1));
            check(tms1 == m_pin(2), "R2 tms1", tms1, m_pin(2));
            for (int i = 0; i < 3; i++)
                check(out_ready[i] == !m_hold_full(i), "R3 out_ready", out_ready[i], !m_hold_full(i));
            check(in_avail == ihf, "R5 in_avail", in_avail, ihf);
            if (ihf) check(in_rdata == ihold, "R5 in_rdata", in_rdata, ihold);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0; out_en = '0; in_en = 0; lpbk_sel = 2'b00; loop_around = 0;
        out_wr = '0; in_rd = 0;
        idle(2);
        // R1 reset values
        check(tck == 0, "R1 tck", tck, 0);
        check(out_ready == 3'b111, "R1 out_ready", out_ready, 3'b111);
        check(in_avail == 0, "R1 in_avail", in_avail, 0);
        check({tdo, tms0, tms1} == 3'b000, "R1 pins", {tdo, tms0, tms1}, 0);
        rst_n = 1;
        idle(1);
    endtask

    task automatic put(input int ch, input logic [7:0] b);
        int guard = 0;
        @(negedge clk); #1;
        while (!out_ready[ch] && guard < 2000) begin @(negedge clk); #1; guard++; end
        out_wdata = b; out_wr[ch] = 1'b1;
        @(negedge clk); #1;
        out_wr = '0;
    endtask

    task automatic get(output logic [7:0] b);
        int guard = 0;
        @(negedge clk); #1;
        while (!in_avail && guard < 2000) begin @(negedge clk); #1; guard++; end
        b = in_rdata; in_rd = 1'b1;
        @(negedge clk); #1;
        in_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] rb;
        logic [7:0] dbytes [4];
        int highs;
        dbytes[0] = 8'hA5; dbytes[1] = 8'h3C; dbytes[2] = 8'h0F; dbytes[3] = 8'hD2;
        idle(2);
        do_reset();

        // R8/R5: stream on all channels, data line looped into the input
        out_en = 3'b111; in_en = 1; lpbk_sel = 2'b01;
        for (int k = 0; k < 2; k++) begin
            put(0, dbytes[k]); put(1, 8'h55 ^ dbytes[k]); put(2, ~dbytes[k]);
        end
        for (int k = 0; k < 4; k++) begin
            get(rb);
            check(rb == dbytes[k], "R8 data loop-back byte", rb, dbytes[k]);
            if (k + 2 < 4) begin
                put(0, dbytes[k+2]); put(1, 8'h55 ^ dbytes[k+2]); put(2, ~dbytes[k+2]);
            end
        end
        idle(40);

        // R8: mode-select 0 as source, R5 LSB-first assembly
        do_reset();
        out_en = 3'b010; in_en = 1; lpbk_sel = 2'b10;
        put(1, 8'h96);
        get(rb);
        check(rb == 8'h96, "R5 R8 ms0 loop-back byte", rb, 8'h96);
        do_reset();
        out_en = 3'b100; in_en = 1; lpbk_sel = 2'b11;
        put(2, 8'h1E);
        get(rb);
        check(rb == 8'h1E, "R8 ms1 loop-back byte", rb, 8'h1E);

        // R6: incoming fills both stages and halts the clock
        do_reset();
        in_en = 1; lpbk_sel = 2'b00;
        idle(60);
        for (int k = 0; k < 8; k++) begin
            check(tck == 0, "R6 tck held low when full", tck, 0);
            idle(1);
        end
        get(rb); get(rb);
        highs = 0;
        for (int k = 0; k < 6; k++) begin idle(1); if (tck) highs++; end
        check(highs > 0, "R6 clock resumes after read", highs, 1);

        // R9: loop-around
        do_reset();
        loop_around = 1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            check(tdo == tdi_pin, "R9 tdo follows tdi_pin", tdo, tdi_pin);
        end
        idle(1);

        // R3: second write while full is dropped
        do_reset();
        put(1, 8'hC3);
        check(out_ready[1] == 0, "R3 ready low when holding full", out_ready[1], 0);
        out_wdata = 8'h11; out_wr[1] = 1'b1;
        idle(1);
        out_wr = '0;
        out_en = 3'b010;
        idle(30);
        check(out_ready[1] == 1, "R3 ready after drain", out_ready[1], 1);
        check(tms0 == 1'b1, "R3 last bit is from first byte", tms0, 1);

        // R10: disabled channel keeps its byte and pin; R4 stall after drain
        do_reset();
        out_en = 3'b001;
        put(2, 8'h5A);
        put(0, 8'h81);
        highs = 0;
        for (int k = 0; k < 30; k++) begin
            idle(1);
            if (tck) highs++;
            check(tms1 == 0, "R10 disabled pin holds", tms1, 0);
        end
        check(highs > 0, "R10 disabled channel does not stall", highs, 1);
        check(out_ready[2] == 0, "R10 disabled byte not consumed", out_ready[2], 0);
        for (int k = 0; k < 10; k++) begin
            check(tck == 0, "R4 empty enabled channel stalls", tck, 0);
            idle(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule